// File: doc/BRIEF.md
# Serial Memory Slave Front End with Transfer Pause

This block is the serial front end of a memory-style slave on an SPI bus (mode 0: SCK idles low). It runs on the system clock and passes chip select, SCK, serial input and the pause input through two-flop synchronizers. It finds SCK edges by comparing consecutive synchronized samples, so the system clock must run at least four times faster than SCK. Bits are captured MSB first on SCK rising edges. Each completed byte goes to the command decoder as a one-cycle strobe. Bytes to be read out are accepted through a valid/ready port and shifted out on SCK falling edges. The serial output has its own output enable, so the pad can be tri-stated.

The pause input (active low) stops a transfer partway through without losing any bits. The pause starts and ends only while SCK is low. While it is paused, SCK and SI activity is ignored. The serial output is disabled whenever the pause input is low. The receive strobe has no back-pressure: the decoder must take every byte in the cycle it is flagged. The read port takes a byte only when `tx_valid_i` and `tx_ready_o` are both high at a clock edge. A byte offered while `tx_ready_o` is low waits and is not lost.

Top module: `spi_hold_front`

## Requirements
- R1: While chip select (synchronized) is high, the device is deselected: `so_oe_o` and `tx_ready_o` are 0, no `rx_valid_o` pulse occurs, and the bit count, the pause state and the staged read byte are all cleared.
- R2: After reset, the device is not selected until chip select has been seen high and then low. A chip select that is already low at reset selects nothing, and SCK activity during that time produces no bytes.
- R3: While selected and not paused, SI is sampled on each SCK rising edge, MSB first. After every 8th sampled bit, `rx_valid_o` is high for exactly one clock with the byte on `rx_data_o`. There is no back-pressure on this output.
- R4: On each SCK falling edge while selected and not paused, `so_o` moves to the next bit, MSB first. At the first falling edge after a byte boundary (bit count 0), the staged read byte is loaded and its bit 7 is driven. If no byte is staged, 8'hFF is shifted out instead. Right after selection, `so_o` is 1.
- R5: `tx_ready_o` is high while the device is selected and the one-byte staging register is empty. A byte is staged when `tx_valid_i` and `tx_ready_o` are both high at a clock edge.
- R6: If the pause input is low while SCK is low, the pause starts at once. While paused, SCK edges are ignored, and the bit count, the received bits and the output shifter keep their values.
- R7: If the pause input goes low while SCK is high, the pause starts at the next SCK falling edge, and that falling edge does not shift the output.
- R8: A pause ends only when the pause input is high while SCK is low. The transfer then continues from the bit at which it stopped. Raising the pause input while SCK is high does not end the pause.
- R9: `so_oe_o` is 0 whenever the synchronized pause input is low, even before a pause has formally begun.
- R10: Deselecting during a pause cancels the pause and clears the bit count. The next selection starts a fresh byte.
- R11: `standby_o` is high exactly when the device is deselected and `busy_i` (an internal write is running) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| si_i | input | 1 | Serial data input |
| hold_n_i | input | 1 | Transfer pause, active low |
| busy_i | input | 1 | An internal write cycle is running |
| so_o | output | 1 | Serial data output value |
| so_oe_o | output | 1 | Output enable for the serial output pad |
| rx_valid_o | output | 1 | One-cycle strobe: a received byte is on rx_data_o |
| rx_data_o | output | DATA_W | Received byte |
| tx_valid_i | input | 1 | Read byte offered |
| tx_data_i | input | DATA_W | Read byte to shift out |
| tx_ready_o | output | 1 | Staging register is able to take a read byte |
| standby_o | output | 1 | Deselected with no internal write running |

## Verification
The hardest state to reach is a pause requested while SCK is high: the pause input has to fall between an SCK rise and the next fall, and then it has to rise again while SCK is still high, so that the release is correctly held off. The stimulus drives SCK and the pause input separately, in whole system-clock steps. This lets it place the pause edge at chosen points relative to each SCK phase. The stimulus also deselects partway through a pause, which checks that the cancelled pause leaves no trace on the next byte. A behavioural model run alongside the design compares every output on every clock cycle.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sck_s,
  input  logic hold_s,
  output logic paused_o,
  output logic gate_o
);
  logic paused_q;
  logic enter, leave;

  // The pause starts or ends only while SCK is low.
  assign enter  = !paused_q && !hold_s && !sck_s;
  assign leave  =  paused_q &&  hold_s && !sck_s;
  assign gate_o = paused_q || enter;
  assign paused_o = paused_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      paused_q <= 1'b0;
    else if (!sel_i) paused_q <= 1'b0;
    else if (enter)  paused_q <= 1'b1;
    else if (leave)  paused_q <= 1'b0;

  assert_release_sck_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused_q) && $past(sel_i)) |-> ($past(hold_s) && !$past(sck_s)));

  assert_deselect_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !paused_q);
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              gate_i,
  input  logic              rise_i,
  input  logic              si_s,
  output logic [CNT_W-1:0]  bitcnt_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              last_bit, take;

  assign take     = sel_i && !gate_i && rise_i;
  assign last_bit = (cnt_q == CNT_W'(DATA_W-1));
  assign bitcnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q      <= '0;
      sh_q       <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!sel_i) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q  <= {sh_q[DATA_W-2:0], si_s};
        cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
        if (last_bit) begin
          rx_valid_o <= 1'b1;
          rx_data_o  <= {sh_q[DATA_W-2:0], si_s};
        end
      end
    end

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_pause_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && sel_i) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W),
  localparam logic [DATA_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              gate_i,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  bitcnt_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              so_o
);
  logic              full_q;
  logic [DATA_W-1:0] stage_q, sh_q;
  logic              step, load_byte;
  logic [DATA_W-1:0] next_byte;

  assign tx_ready_o = sel_i && !full_q;
  assign step       = sel_i && !gate_i && fall_i;
  assign load_byte  = step && (bitcnt_i == '0);
  assign next_byte  = full_q ? stage_q : FILL;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full_q  <= 1'b0;
      stage_q <= '0;
      sh_q    <= FILL;
      so_o    <= 1'b1;
    end else if (!sel_i) begin
      full_q <= 1'b0;
      sh_q   <= FILL;
      so_o   <= 1'b1;
    end else begin
      if (tx_valid_i && tx_ready_o) begin
        full_q  <= 1'b1;
        stage_q <= tx_data_i;
      end else if (load_byte) begin
        full_q <= 1'b0;
      end
      if (load_byte) begin
        so_o <= next_byte[DATA_W-1];
        sh_q <= {next_byte[DATA_W-2:0], 1'b1};
      end else if (step) begin
        so_o <= sh_q[DATA_W-1];
        sh_q <= {sh_q[DATA_W-2:0], 1'b1};
      end
    end

  assert_stage_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front
  import spi_hold_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  input  logic              busy_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              standby_o
);
  logic [3:0] raw, synced;
  logic cs_s, sck_s, si_s, hold_s;
  logic cs_d, sck_d, sel_q;
  logic paused, gate;
  logic [CNT_W-1:0] bitcnt;
  sck_edge_t edge_s;

  assign raw = {cs_n_i, sck_i, si_i, hold_n_i};

  // Chip select resets low so that only a real high-then-low selects.
  spi_in_sync #(.WIDTH(4), .STAGES(SYNC_DEPTH), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );
  assign {cs_s, sck_s, si_s, hold_s} = synced;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_d  <= 1'b0;
      sck_d <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
      if (cs_s)              sel_q <= 1'b0;
      else if (cs_d && !cs_s) sel_q <= 1'b1;
    end

  assign edge_s.rise = sck_s && !sck_d;
  assign edge_s.fall = !sck_s && sck_d;

  spi_hold_ctrl u_hold (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_q), .sck_s(sck_s), .hold_s(hold_s),
    .paused_o(paused), .gate_o(gate)
  );

  spi_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_q), .gate_i(gate), .rise_i(edge_s.rise),
    .si_s(si_s), .bitcnt_o(bitcnt), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  spi_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_q), .gate_i(gate), .fall_i(edge_s.fall),
    .bitcnt_i(bitcnt), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_ready_o(tx_ready_o), .so_o(so_o)
  );

  assign so_oe_o   = sel_q && hold_s && !paused;
  assign standby_o = !sel_q && !busy_i;

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!so_oe_o && !tx_ready_o && !rx_valid_o));

  assert_no_select_without_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && !(cs_d && !cs_s)) |=> !sel_q);
endmodule

// File: tb/spi_hold_front_bench.sv
module spi_hold_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic so, so_oe, rx_valid, tx_ready, standby;
  logic [7:0] rx_data;
  int vectors = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  spi_hold_front u_spi_hold_front (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .hold_n_i(hold_n),
    .busy_i(busy), .so_o(so), .so_oe_o(so_oe), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready), .standby_o(standby)
  );

  // Behavioural reference: input history queues and plain integers.
  bit cs_h[$], sck_h[$], si_h[$], hold_h[$];
  bit m_csp, m_sckp, m_sel, m_pause, m_full, m_rxv, m_so;
  int m_cnt, m_rxbyte, m_rxout, m_stage, m_txsh;

  task automatic model_reset();
    cs_h = {0, 0}; sck_h = {0, 0}; si_h = {0, 0}; hold_h = {1, 1};
    m_csp = 0; m_sckp = 0; m_sel = 0; m_pause = 0; m_full = 0; m_rxv = 0; m_so = 1;
    m_cnt = 0; m_rxbyte = 0; m_rxout = 0; m_stage = 0; m_txsh = 255;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit c, k, d, h, rise, fall, busy_gate, rdy, nsel;
      int b;
      c = cs_h[1]; k = sck_h[1]; d = si_h[1]; h = hold_h[1];
      rise = k && !m_sckp; fall = !k && m_sckp;
      busy_gate = m_pause || (!h && !k);
      rdy = m_sel && !m_full;
      nsel = c ? 0 : ((m_csp && !c) ? 1 : m_sel);
      m_rxv = 0;
      if (!m_sel) begin
        m_cnt = 0; m_pause = 0; m_full = 0; m_so = 1; m_txsh = 255;
      end else begin
        if (rise && !busy_gate) begin
          m_rxbyte = ((m_rxbyte << 1) | d) & 255;
          if (m_cnt == 7) begin m_rxv = 1; m_rxout = m_rxbyte; m_cnt = 0; end
          else m_cnt++;
        end
        if (fall && !busy_gate) begin
          if (m_cnt == 0) begin
            b = m_full ? m_stage : 255;
            if (m_full) m_full = 0;
          end else b = m_txsh;
          m_so = b[7];
          m_txsh = ((b << 1) | 1) & 255;
        end
        if (tx_valid && rdy) begin m_full = 1; m_stage = tx_data; end
        if (!m_pause && !h && !k) m_pause = 1;
        else if (m_pause && h && !k) m_pause = 0;
      end
      m_sel = nsel; m_csp = c; m_sckp = k;
      cs_h.push_front(cs_n); void'(cs_h.pop_back());
      sck_h.push_front(sck); void'(sck_h.pop_back());
      si_h.push_front(si); void'(si_h.pop_back());
      hold_h.push_front(hold_n); void'(hold_h.pop_back());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit exp_oe;
      exp_oe = m_sel && hold_h[1] && !m_pause;
      check("R1/R2/R9/R6/R7 so_oe", {7'd0, so_oe}, {7'd0, exp_oe});
      if (exp_oe) check("R4/R7/R8 so_out", {7'd0, so}, {7'd0, m_so});
      check("R2/R3/R10 rx_valid", {7'd0, rx_valid}, {7'd0, m_rxv});
      if (m_rxv) check("R3/R6/R8/R10 rx_data", rx_data, m_rxout[7:0]);
      check("R5 tx_ready", {7'd0, tx_ready}, {7'd0, m_sel && !m_full});
      check("R11 standby", {7'd0, standby}, {7'd0, !m_sel && !busy});
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(bit b);
    si = b; tick(4); sck = 1; tick(4); sck = 0;
  endtask

  task automatic send_byte(logic [7:0] d);
    for (int i = 7; i >= 0; i--) clk_bit(d[i]);
  endtask

  task automatic push_tx(logic [7:0] d);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = d;
    @(negedge clk);
    tx_valid = 0;
  endtask

  initial begin
    tick(5); rst_n = 1; tick(4);
    send_byte(8'h81);                        // R2: low at reset selects nothing
    cs_n = 1; tick(6);
    busy = 1; tick(4); busy = 0; tick(2);    // R11
    cs_n = 0; tick(6);
    push_tx(8'h3C);                          // R5
    send_byte(8'hA5);                        // R3
    send_byte(8'h5A);                        // R4: 3C shifted out
    send_byte(8'hC3);                        // R4: no staged byte, FF
    // R6/R8: pause with SCK low, edges ignored, resume
    push_tx(8'h96);
    clk_bit(1); clk_bit(0); clk_bit(1);
    hold_n = 0; tick(3);
    si = 0; sck = 1; tick(4); sck = 0; tick(4); sck = 1; tick(4); sck = 0; tick(4);
    hold_n = 1; tick(4);
    clk_bit(1); clk_bit(0); clk_bit(0); clk_bit(1); clk_bit(1);
    // R7/R8: pause requested with SCK high, release attempt while high
    si = 1; tick(4); sck = 1; tick(2);
    hold_n = 0; tick(4); sck = 0; tick(4);
    sck = 1; tick(4); hold_n = 1; tick(4); sck = 0; tick(4);
    clk_bit(0); clk_bit(1); clk_bit(1); clk_bit(0);
    clk_bit(1); clk_bit(0); clk_bit(0); clk_bit(1);
    // R9: short pause pulse with SCK high, never takes effect
    si = 0; tick(4); sck = 1; tick(1); hold_n = 0; tick(3); hold_n = 1; tick(4); sck = 0;
    send_byte(8'h11);
    // R10: deselect during pause, fresh byte afterwards
    clk_bit(1); clk_bit(1); clk_bit(0);
    hold_n = 0; tick(4);
    cs_n = 1; tick(6); hold_n = 1; tick(4);
    cs_n = 0; tick(6);
    send_byte(8'h7E);
    cs_n = 1; busy = 1; tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule